// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge Interface

This block sits between a set of interrupt sources and one processor. It holds a pending and an active flag for each source, picks the best pending source, and raises an interrupt request line toward the processor when that source is allowed through. The processor uses a small register window to control it. One register holds the enable. One holds a priority threshold. A read-sensitive acknowledge register hands over the winning source. An end-of-interrupt register retires that source once it has been serviced.

Each source's priority value and trigger style (level or rising edge) are inputs supplied by the surrounding logic. A lower priority value is more urgent. Source index i is reported as ID i. The reserved ID 1023 means that nothing was available. Only one source can be active at a time. While a source is active, the request line stays low and acknowledge reads return 1023 until the end-of-interrupt write arrives.

The register window has a one-cycle write strobe and a one-cycle read strobe. Read data is registered and appears together with `reg_rvalid` one cycle after the read strobe. The register selected by `reg_addr` is:

| `reg_addr` | Register |
|------------|----------|
| 0 | control |
| 1 | priority threshold |
| 2 | acknowledge |
| 3 | end-of-interrupt |

Top module: `icpu_ack_if`

## Requirements
- R1: After reset the interrupt request is low, the control and threshold registers read 0, and an acknowledge read returns 1023.
- R2: Bit 0 of the control register (address 0) enables signalling. While it is 0, the request stays low and an acknowledge read returns 1023.
- R3: The priority threshold register (address 1) holds 8 bits. A pending source qualifies only if its priority value is strictly below the threshold. A value equal to the threshold does not qualify.
- R4: Among qualifying sources, the lowest priority value wins. Ties go to the lowest source ID.
- R5: An acknowledge read (address 2) of a qualifying winner returns that ID in bits [9:0], with bits [31:10] at zero. The read clears the source's pending flag and sets its active flag. The request line is low from the cycle after the read.
- R6: When no source qualifies, an acknowledge read returns 1023 and leaves all pending and active state unchanged.
- R7: While any source is active, the request stays low and acknowledge reads return 1023.
- R8: Writing an ID in bits [9:0] to the end-of-interrupt register (address 3) clears that source's active flag. Writing an ID that is not active has no effect.
- R9: A level source (trigger input 0) is pending whenever its line is high and it is not active. It becomes pending again after end-of-interrupt if its line is still high.
- R10: An edge source (trigger input 1) becomes pending on a rising edge of its line, and the acknowledge clears that pending flag. A line held high after end-of-interrupt does not make it pending again.
- R11: A control read returns only bit 0. A threshold read returns only the low 8 bits written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 threshold, 2 acknowledge, 3 end-of-interrupt |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| src_line | input | NSRC | Interrupt lines of the sources |
| src_edge | input | NSRC | Trigger style for each source: 1 edge, 0 level |
| src_prio | input | NSRC*PW | Priority value for each source, source i in bits [i*PW +: PW] |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with NSRC = 6 and PW = 8. Six sources is not a power of two, so the linear pick sees an odd tail. Six sources are also few enough that equal priorities, a source exactly at the threshold, and the most relaxed threshold (0xFF against priority 0xF0) can all be placed in one small table of patterns. On top of the table it runs sequences for the single active level: a second acknowledge while a source is active, an end-of-interrupt with the wrong ID, and the re-pend of a level line still held high. It also tests an edge source whose line stays high across end-of-interrupt.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int IDW = 10;
  localparam logic [IDW-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/icpu_src_state.sv
// Pending and active flags for every source, one generate slice each.
module icpu_src_state #(
  parameter int NSRC = 16,
  parameter int IDW  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] line,
  input  logic [NSRC-1:0] edge_cfg,
  input  logic            take,
  input  logic [IDW-1:0]  take_id,
  input  logic            done,
  input  logic [IDW-1:0]  done_id,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] act
);
  logic [NSRC-1:0] line_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic take_i;
    logic done_i;
    assign take_i = take && (take_id == IDW'(i));
    assign done_i = done && (done_id == IDW'(i)) && act[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[i] <= 1'b0;
        pend[i]   <= 1'b0;
        act[i]    <= 1'b0;
      end else begin
        line_q[i] <= line[i];
        if (take_i)      act[i] <= 1'b1;
        else if (done_i) act[i] <= 1'b0;
        if (edge_cfg[i]) begin
          if (take_i)                      pend[i] <= 1'b0;
          else if (line[i] && !line_q[i])  pend[i] <= 1'b1;
        end else begin
          pend[i] <= line[i] && !act[i] && !take_i;
        end
      end
    end
  end
endmodule

// File: rtl/icpu_pick.sv
// Chooses the pending source with the lowest priority value, lowest ID on ties.
module icpu_pick #(
  parameter int NSRC = 16,
  parameter int PW   = 8,
  parameter int IDW  = 10
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio,
  output logic               found,
  output logic [IDW-1:0]     win_id,
  output logic [PW-1:0]      win_prio
);
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!found || prio[i*PW +: PW] < win_prio)) begin
        found    = 1'b1;
        win_id   = IDW'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/icpu_regs.sv
// Register window, qualification and the registered request line.
module icpu_regs
  import icpu_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           re,
  input  logic [1:0]     addr,
  input  logic [31:0]    wdata,
  input  logic           cand_found,
  input  logic [IDW-1:0] cand_id,
  input  logic [PW-1:0]  cand_prio,
  input  logic           act_any,
  output logic           en,
  output logic [PW-1:0]  pmask,
  output logic           qual,
  output logic           take,
  output logic [IDW-1:0] take_id,
  output logic           done,
  output logic [IDW-1:0] done_id,
  output logic [31:0]    rdata,
  output logic           rvalid,
  output logic           irq
);
  reg_sel_e sel;
  assign sel     = reg_sel_e'(addr);
  assign qual    = en && cand_found && (cand_prio < pmask) && !act_any;
  assign take    = re && (sel == REG_ACK) && qual;
  assign take_id = cand_id;
  assign done    = we && (sel == REG_EOI);
  assign done_id = wdata[IDW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      pmask  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (we && sel == REG_CTRL)  en    <= wdata[0];
      if (we && sel == REG_PMASK) pmask <= wdata[PW-1:0];
      rvalid <= re;
      if (re) begin
        case (sel)
          REG_CTRL:  rdata <= {31'd0, en};
          REG_PMASK: rdata <= 32'(pmask);
          REG_ACK:   rdata <= 32'(qual ? cand_id : SPURIOUS_ID);
          default:   rdata <= '0;
        endcase
      end
      irq <= qual && !take;
    end
  end
endmodule

// File: rtl/icpu_ack_if.sv
module icpu_ack_if
  import icpu_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int PW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid,
  input  logic [NSRC-1:0]    src_line,
  input  logic [NSRC-1:0]    src_edge,
  input  logic [NSRC*PW-1:0] src_prio,
  output logic               irq
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] act;
  logic            cand_found;
  logic [IDW-1:0]  cand_id;
  logic [PW-1:0]   cand_prio;
  logic            en;
  logic [PW-1:0]   pmask;
  logic            qual;
  logic            take;
  logic [IDW-1:0]  take_id;
  logic            done;
  logic [IDW-1:0]  done_id;

  icpu_src_state #(.NSRC(NSRC), .IDW(IDW)) u_state (
    .clk(clk), .rst(rst), .line(src_line), .edge_cfg(src_edge),
    .take(take), .take_id(take_id), .done(done), .done_id(done_id),
    .pend(pend), .act(act)
  );

  icpu_pick #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_pick (
    .pend(pend), .prio(src_prio),
    .found(cand_found), .win_id(cand_id), .win_prio(cand_prio)
  );

  icpu_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .cand_found(cand_found), .cand_id(cand_id),
    .cand_prio(cand_prio), .act_any(|act), .en(en), .pmask(pmask),
    .qual(qual), .take(take), .take_id(take_id), .done(done),
    .done_id(done_id), .rdata(reg_rdata), .rvalid(reg_rvalid), .irq(irq)
  );
endmodule

// File: rtl/icpu_ack_if_chk.sv
module icpu_ack_if_chk #(
  parameter int NSRC = 16,
  parameter int PW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_re,
  input logic [1:0]      reg_addr,
  input logic [31:0]     reg_rdata,
  input logic            irq,
  input logic            en,
  input logic [PW-1:0]   pmask,
  input logic [NSRC-1:0] act,
  input logic            qual
);
  p_irq_after_enable_r2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en));
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
  p_zero_mask_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (pmask == '0) |=> !irq);
  p_one_active_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act));
  p_no_irq_when_active_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (act == '0));
  p_spurious_value_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == 2'd2 && !qual) |=> (reg_rdata == 32'd1023));
  p_ack_result_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == 2'd2 && qual) |=>
      (reg_rdata[31:10] == '0 && reg_rdata[9:0] < 10'(NSRC) && $countones(act) == 1));
endmodule

bind icpu_ack_if icpu_ack_if_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .reg_re(reg_re), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .en(en), .pmask(pmask),
  .act(act), .qual(qual)
);

// File: tb/icpu_ack_if_tb.sv
module icpu_ack_if_tb;
  localparam int NSRC = 6;
  localparam int PW   = 8;
  localparam int NVEC = 8;
  // each entry: {line pattern[23:18], threshold[17:10], expected ID[9:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {6'b000001, 8'hFF, 10'd0},
    {6'b001010, 8'hFF, 10'd1},
    {6'b011111, 8'hFF, 10'd4},
    {6'b000101, 8'h40, 10'd1023},
    {6'b000101, 8'h41, 10'd0},
    {6'b100000, 8'hFF, 10'd5},
    {6'b100000, 8'hF0, 10'd1023},
    {6'b000100, 8'hFF, 10'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic [NSRC-1:0] src_line = '0;
  logic [NSRC-1:0] src_edge = '0;
  logic [NSRC*PW-1:0] src_prio = {8'hF0, 8'h10, 8'h20, 8'h80, 8'h20, 8'h40};
  logic irq;
  int errors = 0;
  int checks = 0;
  logic [31:0] rd_val;

  always #4 clk = ~clk;

  icpu_ack_if #(.NSRC(NSRC), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .src_line(src_line), .src_edge(src_edge),
    .src_prio(src_prio), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(2'd0, rd_val); chk("R1 ctrl", rd_val, 0);
    rd(2'd1, rd_val); chk("R1 pmask", rd_val, 0);
    rd(2'd2, rd_val); chk("R1 ack", rd_val, 1023);

    // R11 readback widths
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rd_val); chk("R11 ctrl", rd_val, 1);
    wr(2'd1, 32'h0000_01A5);
    rd(2'd1, rd_val); chk("R11 pmask", rd_val, 32'hA5);

    // table of level patterns: R3 R4 R5
    wr(2'd1, 32'hFF);
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd1, 32'(VEC[v][17:10]));
      src_line = VEC[v][23:18];
      idle(3);
      chk($sformatf("R3/R4 irq vec%0d", v), 32'(irq), 32'(VEC[v][9:0] != 10'd1023));
      rd(2'd2, rd_val);
      chk($sformatf("R4/R5 ack vec%0d", v), rd_val, 32'(VEC[v][9:0]));
      if (VEC[v][9:0] != 10'd1023) chk($sformatf("R5 irq drop vec%0d", v), 32'(irq), 0);
      src_line = '0;
      if (VEC[v][9:0] != 10'd1023) wr(2'd3, 32'(VEC[v][9:0]));
      idle(3);
    end

    // R2 enable gating
    wr(2'd1, 32'hFF);
    wr(2'd0, 32'h0);
    src_line = 6'b000001;
    idle(3);
    chk("R2 irq off", 32'(irq), 0);
    rd(2'd2, rd_val); chk("R2 ack off", rd_val, 1023);
    wr(2'd0, 32'h1);
    idle(2);
    chk("R2 irq on", 32'(irq), 1);

    // R6 blocked read keeps pending state
    wr(2'd1, 32'h40);
    idle(2);
    rd(2'd2, rd_val); chk("R6 spurious", rd_val, 1023);
    wr(2'd1, 32'hFF);
    idle(2);
    rd(2'd2, rd_val); chk("R6 pending kept", rd_val, 0);

    // R7 single active level, R8 eoi matching
    src_line = 6'b010001;
    idle(3);
    chk("R7 irq while active", 32'(irq), 0);
    rd(2'd2, rd_val); chk("R7 ack while active", rd_val, 1023);
    wr(2'd3, 32'd4);
    idle(2);
    rd(2'd2, rd_val); chk("R8 wrong eoi", rd_val, 1023);
    src_line = 6'b000001;
    wr(2'd3, 32'd0);
    idle(3);
    // R9 level line still high re-pends
    chk("R9 irq repend", 32'(irq), 1);
    rd(2'd2, rd_val); chk("R9 ack repend", rd_val, 0);
    src_line = '0;
    wr(2'd3, 32'd0);
    idle(3);
    chk("R9 low no repend", 32'(irq), 0);
    rd(2'd2, rd_val); chk("R9 ack low", rd_val, 1023);

    // R10 edge source
    src_edge = 6'b000010;
    src_line = 6'b000010;
    idle(3);
    chk("R10 edge irq", 32'(irq), 1);
    rd(2'd2, rd_val); chk("R10 edge ack", rd_val, 1);
    wr(2'd3, 32'd1);
    idle(3);
    chk("R10 held high no irq", 32'(irq), 0);
    rd(2'd2, rd_val); chk("R10 held high ack", rd_val, 1023);
    src_line = '0;
    idle(2);
    src_line = 6'b000010;
    idle(3);
    rd(2'd2, rd_val); chk("R10 new edge ack", rd_val, 1);
    wr(2'd3, 32'd1);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule